// File: doc/BRIEF.md
# Multi-Channel Mailbox Doorbell Controller

This block connects a host processor to an embedded remote controller. It has twelve independent message channels. Each channel owns two fixed windows in one shared word RAM: an outgoing (host-to-remote) window and an incoming (remote-to-host) window. The windows differ in length. The outgoing windows lie below byte offset 0xE0 and the incoming windows lie from 0xE0 up to 0x16F. The host loads an outgoing window with word writes and then rings the channel's doorbell through a small control register file. The remote side sees the doorbell vector, reads the payload through its own port, and acknowledges it. Replies travel the other way. The remote side writes an incoming window and posts the channel. This sets a receive flag, and the flag drives the single host interrupt until the host clears it.

The host port is word-wide with byte addressing. Addresses from 0x000 to 0x16F reach the data RAM. Addresses at and above 0x200 reach the control registers. Both reads and writes complete in one cycle, and read data appears on the cycle after the request. The remote port addresses the RAM by word index.

Top module: `mbx_doorbell_top`

## Requirements
- R1: After reset, every outgoing-pending bit and every receive bit is 0, `host_irq` is low, and all data words read as 0.
- R2: A host write to control address 0x204 sets the outgoing-pending bit of each channel whose data bit (bit index = channel number) is 1. Bits written as 0 leave their channel unchanged. The pending vector shows on `rmt_doorbell` and reads back at control address 0x200 from the next cycle.
- R3: `rmt_ack[i]` clears outgoing-pending bit i. If a host doorbell write and an acknowledge hit the same channel in the same cycle, the bit ends up set.
- R4: `rmt_post[i]` sets receive bit i, which reads back at control address 0x278. A host write of 1 to bit i at control address 0x274 clears it. If a post and a clear hit the same bit in the same cycle, the bit stays set.
- R5: `host_irq` is high exactly while at least one receive bit is set.
- R6: Control addresses 0x204 and 0x274 read as 0. Control addresses other than 0x200, 0x204, 0x274 and 0x278 read as 0, and writes to them have no effect. Data bits 12 and above are ignored on write and read as 0.
- R7: A host word written below byte address 0xE0 reads back on both ports. Host read data appears on the cycle after the request. Remote read data appears on the cycle after the word index is presented. Host addresses from 0x170 to 0x1FF and remote indices of 92 and above read as 0.
- R8: Remote writes land only at word indices 56 to 91 (bytes 0xE0 to 0x16F), and the host reads them back. Remote writes to lower indices are ignored. Host writes at byte 0xE0 and above in the data region are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 10 | Host byte address; bit 9 selects the control region |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after a read request |
| host_irq | output | 1 | Shared receive interrupt to the host |
| rmt_addr | input | 7 | Remote word index into the data RAM |
| rmt_we | input | 1 | Remote write enable |
| rmt_wdata | input | 32 | Remote write data |
| rmt_rdata | output | 32 | Remote read data, one cycle after `rmt_addr` |
| rmt_ack | input | 12 | Per-channel acknowledge of an outgoing message |
| rmt_post | input | 12 | Per-channel post of an incoming message |
| rmt_doorbell | output | 12 | Outgoing-pending vector toward the remote side |

## Verification
Two pairs of events can land on the same channel in the same clock. A remote post can coincide with a host interrupt-clear on one receive bit, and a host doorbell write can coincide with a remote acknowledge on one outgoing bit. The bench drives each pair on the same falling edge so both are sampled at one rising edge. It then reads the status register back through the host port and compares the result with the rule that the setting event wins. A clean post/clear sequence and a clean set/ack sequence also run first, so the collision results can be told apart from plain set or clear behaviour.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   // host read source selected at request time
   typedef enum logic [1:0] {
      SRC_ZERO = 2'd0,
      SRC_DATA = 2'd1,
      SRC_TX   = 2'd2,
      SRC_RX   = 2'd3
   } rd_src_e;

   // control offsets (decoded by host software, so they are fixed)
   localparam int unsigned OFF_TX_STS  = 'h00;
   localparam int unsigned OFF_DB_SET  = 'h04;
   localparam int unsigned OFF_IRQ_CLR = 'h74;
   localparam int unsigned OFF_RX_STS  = 'h78;

   localparam int unsigned MAP_CH      = 12;
   localparam int unsigned MAX_IN_LEN  = 32;

   typedef struct packed {
      logic [31:0] tx_off;
      logic [31:0] tx_len;
      logic [31:0] rx_off;
      logic [31:0] rx_len;
   } win_t;

   // fixed window map, byte offsets and lengths
   function automatic win_t win_of(input int ch);
      case (ch)
         0:  return '{32'h000, 32'd16, 32'h0E0, 32'd16};
         1:  return '{32'h010, 32'd32, 32'h0F0, 32'd32};
         2:  return '{32'h030, 32'd12, 32'h110, 32'd4};
         3:  return '{32'h03C, 32'd24, 32'h114, 32'd4};
         4:  return '{32'h054, 32'd36, 32'h118, 32'd4};
         5:  return '{32'h078, 32'd16, 32'h11C, 32'd16};
         6:  return '{32'h088, 32'd24, 32'h12C, 32'd4};
         7:  return '{32'h0A0, 32'd24, 32'h130, 32'd24};
         8:  return '{32'h0B8, 32'd4,  32'h148, 32'd16};
         9:  return '{32'h0BC, 32'd16, 32'h158, 32'd4};
         10: return '{32'h0CC, 32'd16, 32'h15C, 32'd16};
         11: return '{32'h0DC, 32'd4,  32'h16C, 32'd4};
         default: return '0;
      endcase
   endfunction

endpackage

// File: rtl/mbx_host_decode.sv
module mbx_host_decode #(
   parameter int NUM_CH   = 12,
   parameter int DW       = 32,
   parameter int AW       = 10,
   parameter int WAW      = 7,
   parameter int WORDS    = 92,
   parameter int RX_WORD  = 56,
   parameter int CTL_BASE = 'h200
) (
   input  logic              host_req,
   input  logic              host_we,
   input  logic [AW-1:0]     host_addr,
   input  logic [DW-1:0]     host_wdata,
   output logic              dat_wr,
   output logic [WAW-1:0]    dat_idx,
   output logic [NUM_CH-1:0] db_set,
   output logic [NUM_CH-1:0] irq_clr,
   output mbx_pkg::rd_src_e  rd_src
);
   import mbx_pkg::*;

   localparam logic [AW-1:0] CTL_A   = AW'(CTL_BASE);
   localparam logic [AW-1:0] A_TX    = AW'(OFF_TX_STS);
   localparam logic [AW-1:0] A_DB    = AW'(OFF_DB_SET);
   localparam logic [AW-1:0] A_CLR   = AW'(OFF_IRQ_CLR);
   localparam logic [AW-1:0] A_RX    = AW'(OFF_RX_STS);
   localparam logic [AW-3:0] W_END   = (AW-2)'(WORDS);
   localparam logic [AW-3:0] W_RX    = (AW-2)'(RX_WORD);

   logic          in_ctl;
   logic          in_data;
   logic          in_tx;
   logic [AW-1:0] off;
   logic [AW-3:0] widx;
   logic          wr;

   assign in_ctl  = host_addr >= CTL_A;
   assign off     = host_addr - CTL_A;
   assign widx    = host_addr[AW-1:2];
   assign in_data = !in_ctl && (widx < W_END);
   assign in_tx   = in_data && (widx < W_RX);
   assign wr      = host_req && host_we;

   assign dat_wr  = wr && in_tx;
   assign dat_idx = WAW'(widx);
   assign db_set  = (wr && in_ctl && off == A_DB)  ? host_wdata[NUM_CH-1:0] : '0;
   assign irq_clr = (wr && in_ctl && off == A_CLR) ? host_wdata[NUM_CH-1:0] : '0;

   always_comb begin
      rd_src = SRC_ZERO;
      if (in_ctl) begin
         if (off == A_TX)      rd_src = SRC_TX;
         else if (off == A_RX) rd_src = SRC_RX;
      end else if (in_data) begin
         rd_src = SRC_DATA;
      end
   end

endmodule

// File: rtl/mbx_word_ram.sv
module mbx_word_ram #(
   parameter int DW      = 32,
   parameter int WORDS   = 92,
   parameter int WAW     = 7,
   parameter int RX_WORD = 56
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           h_we,
   input  logic           h_rd_en,
   input  logic [WAW-1:0] h_idx,
   input  logic [DW-1:0]  h_wdata,
   output logic [DW-1:0]  h_rdata,
   input  logic           r_we,
   input  logic [WAW-1:0] r_idx,
   input  logic [DW-1:0]  r_wdata,
   output logic [DW-1:0]  r_rdata
);
   localparam logic [WAW:0] END_W = (WAW+1)'(WORDS);
   localparam logic [WAW:0] RX_W  = (WAW+1)'(RX_WORD);

   logic [DW-1:0] mem [WORDS];
   logic          r_in_range;
   logic          r_wr_ok;

   assign r_in_range = {1'b0, r_idx} < END_W;
   // remote side may only fill the incoming windows
   assign r_wr_ok    = r_we && r_in_range && ({1'b0, r_idx} >= RX_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      end else begin
         if (h_we)    mem[h_idx] <= h_wdata;
         if (r_wr_ok) mem[r_idx] <= r_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_rdata <= '0;
         r_rdata <= '0;
      end else begin
         if (h_rd_en) h_rdata <= mem[h_idx];
         r_rdata <= r_in_range ? mem[r_idx] : '0;
      end
   end

endmodule

// File: rtl/mbx_chan_flags.sv
module mbx_chan_flags #(
   parameter int NUM_CH   = 12,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] db_set,
   input  logic [NUM_CH-1:0] ack,
   input  logic [NUM_CH-1:0] post,
   input  logic [NUM_CH-1:0] clr,
   output logic [NUM_CH-1:0] tx_sts,
   output logic [NUM_CH-1:0] rx_sts
);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic tx_b;
      logic rx_b;
      logic tx_nxt;

      if (SET_WINS) begin : g_set_first
         assign tx_nxt = db_set[c] ? 1'b1 : (ack[c] ? 1'b0 : tx_b);
      end else begin : g_ack_first
         assign tx_nxt = ack[c] ? 1'b0 : (db_set[c] ? 1'b1 : tx_b);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tx_b <= 1'b0;
            rx_b <= 1'b0;
         end else begin
            tx_b <= tx_nxt;
            if (post[c])     rx_b <= 1'b1;
            else if (clr[c]) rx_b <= 1'b0;
         end
      end

      assign tx_sts[c] = tx_b;
      assign rx_sts[c] = rx_b;

      // R1
      rst_clear_chk: assert property (@(posedge clk) !rst_n |=> (!tx_b && !rx_b));
      // R2
      db_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (db_set[c] && (SET_WINS || !ack[c])) |=> tx_b);
      // R3
      ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ack[c] && !db_set[c]) |=> !tx_b);
      // R4
      post_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
         post[c] |=> rx_b);
      // R4
      host_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[c] && !post[c]) |=> !rx_b);
   end

endmodule

// File: rtl/mbx_doorbell_top.sv
module mbx_doorbell_top #(
   parameter int NUM_CH     = 12,
   parameter int DW         = 32,
   parameter int AW         = 10,
   parameter int DATA_BYTES = 'h170,
   parameter int RX_BASE    = 'hE0,
   parameter int CTL_BASE   = 'h200,
   parameter bit SET_WINS   = 1'b1,
   localparam int WORDS     = DATA_BYTES / 4,
   localparam int RX_WORD   = RX_BASE / 4,
   localparam int WAW       = $clog2(WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [AW-1:0]     host_addr,
   input  logic [DW-1:0]     host_wdata,
   output logic [DW-1:0]     host_rdata,
   output logic              host_irq,
   input  logic [WAW-1:0]    rmt_addr,
   input  logic              rmt_we,
   input  logic [DW-1:0]     rmt_wdata,
   output logic [DW-1:0]     rmt_rdata,
   input  logic [NUM_CH-1:0] rmt_ack,
   input  logic [NUM_CH-1:0] rmt_post,
   output logic [NUM_CH-1:0] rmt_doorbell
);
   import mbx_pkg::*;

   // ---------------- elaboration-time parameter checks ----------------
   if (NUM_CH > DW || NUM_CH > int'(MAP_CH)) begin : g_bad_ch
      $error("mbx_doorbell_top: NUM_CH exceeds data width or window map");
   end
   if ((DATA_BYTES % 4) != 0 || (RX_BASE % 4) != 0 || RX_BASE >= DATA_BYTES) begin : g_bad_geom
      $error("mbx_doorbell_top: data region geometry is not word aligned");
   end
   if (CTL_BASE < DATA_BYTES || CTL_BASE >= (1 << AW)) begin : g_bad_ctl
      $error("mbx_doorbell_top: control base overlaps data or lies outside the address range");
   end
   for (genvar c = 0; c < NUM_CH; c++) begin : g_win_chk
      localparam win_t W = win_of(c);
      if (W.tx_off + W.tx_len > RX_BASE || W.rx_off < RX_BASE ||
          W.rx_off + W.rx_len > DATA_BYTES || W.rx_len > MAX_IN_LEN ||
          (W.tx_len % 4) != 0 || (W.rx_len % 4) != 0 ||
          (W.tx_off % 4) != 0 || (W.rx_off % 4) != 0) begin : g_bad_win
         $error("mbx_doorbell_top: channel window outside its region");
      end
   end

   // ---------------- datapath ----------------
   logic              dat_wr;
   logic [WAW-1:0]    dat_idx;
   logic [NUM_CH-1:0] db_set;
   logic [NUM_CH-1:0] irq_clr;
   rd_src_e           rd_src;
   logic [NUM_CH-1:0] tx_sts;
   logic [NUM_CH-1:0] rx_sts;
   logic [DW-1:0]     ram_q;
   logic              rd_req;
   rd_src_e           src_q;
   logic [NUM_CH-1:0] ctl_q;

   mbx_host_decode #(
      .NUM_CH(NUM_CH), .DW(DW), .AW(AW), .WAW(WAW),
      .WORDS(WORDS), .RX_WORD(RX_WORD), .CTL_BASE(CTL_BASE)
   ) i_dec (
      .host_req  (host_req),
      .host_we   (host_we),
      .host_addr (host_addr),
      .host_wdata(host_wdata),
      .dat_wr    (dat_wr),
      .dat_idx   (dat_idx),
      .db_set    (db_set),
      .irq_clr   (irq_clr),
      .rd_src    (rd_src)
   );

   assign rd_req = host_req && !host_we;

   mbx_word_ram #(
      .DW(DW), .WORDS(WORDS), .WAW(WAW), .RX_WORD(RX_WORD)
   ) i_ram (
      .clk    (clk),
      .rst_n  (rst_n),
      .h_we   (dat_wr),
      .h_rd_en(rd_req && rd_src == SRC_DATA),
      .h_idx  (dat_idx),
      .h_wdata(host_wdata),
      .h_rdata(ram_q),
      .r_we   (rmt_we),
      .r_idx  (rmt_addr),
      .r_wdata(rmt_wdata),
      .r_rdata(rmt_rdata)
   );

   mbx_chan_flags #(
      .NUM_CH(NUM_CH), .SET_WINS(SET_WINS)
   ) i_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .db_set(db_set),
      .ack   (rmt_ack),
      .post  (rmt_post),
      .clr   (irq_clr),
      .tx_sts(tx_sts),
      .rx_sts(rx_sts)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= SRC_ZERO;
         ctl_q <= '0;
      end else if (rd_req) begin
         src_q <= rd_src;
         ctl_q <= (rd_src == SRC_TX) ? tx_sts : rx_sts;
      end
   end

   always_comb begin
      case (src_q)
         SRC_DATA:       host_rdata = ram_q;
         SRC_TX, SRC_RX: host_rdata = DW'(ctl_q);
         default:        host_rdata = '0;
      endcase
   end

   assign host_irq     = |rx_sts;
   assign rmt_doorbell = tx_sts;

   // R5
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_irq) |-> $past(|rmt_post));
   // R6
   wo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && host_addr == AW'(CTL_BASE + OFF_DB_SET)) |=> (host_rdata == '0));

endmodule

// File: tb/test_mbx_doorbell_top.sv
module test_mbx_doorbell_top;

   localparam int OP_HW = 0;
   localparam int OP_HR = 1;
   localparam int OP_PO = 2;
   localparam int OP_AK = 3;

   typedef struct packed {
      logic [1:0]  op;
      logic [9:0]  addr;
      logic [31:0] val;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int N_VEC = 24;
   localparam vec_t VEC [N_VEC] = '{
      '{2'd0, 10'h204, 32'h0000_0005, 32'h0,         4'd2}, // R2 ring ch0, ch2
      '{2'd1, 10'h200, 32'h0,         32'h0000_0005, 4'd2}, // R2
      '{2'd0, 10'h204, 32'hFFFF_F000, 32'h0,         4'd6}, // R6 high bits
      '{2'd1, 10'h200, 32'h0,         32'h0000_0005, 4'd6}, // R6
      '{2'd3, 10'h000, 32'h0000_0001, 32'h0,         4'd3}, // R3 ack ch0
      '{2'd1, 10'h200, 32'h0,         32'h0000_0004, 4'd3}, // R3
      '{2'd2, 10'h000, 32'h0000_0810, 32'h0,         4'd4}, // R4 post ch4, ch11
      '{2'd1, 10'h278, 32'h0,         32'h0000_0810, 4'd4}, // R4
      '{2'd1, 10'h274, 32'h0,         32'h0,         4'd6}, // R6 write-only
      '{2'd1, 10'h204, 32'h0,         32'h0,         4'd6}, // R6 write-only
      '{2'd0, 10'h274, 32'h0000_0010, 32'h0,         4'd4}, // R4 clear ch4
      '{2'd1, 10'h278, 32'h0,         32'h0000_0800, 4'd4}, // R4
      '{2'd0, 10'h274, 32'h0000_0800, 32'h0,         4'd4}, // R4 clear ch11
      '{2'd1, 10'h278, 32'h0,         32'h0,         4'd4}, // R4
      '{2'd0, 10'h000, 32'hA5A5_0001, 32'h0,         4'd7}, // R7 first TX word
      '{2'd0, 10'h0DC, 32'h1234_5678, 32'h0,         4'd7}, // R7 last TX word
      '{2'd1, 10'h000, 32'h0,         32'hA5A5_0001, 4'd7}, // R7
      '{2'd1, 10'h0DC, 32'h0,         32'h1234_5678, 4'd7}, // R7
      '{2'd0, 10'h0E0, 32'hDEAD_BEEF, 32'h0,         4'd8}, // R8 host into RX area
      '{2'd1, 10'h0E0, 32'h0,         32'h0,         4'd8}, // R8
      '{2'd0, 10'h240, 32'h0000_0FFF, 32'h0,         4'd6}, // R6 unmapped offset
      '{2'd1, 10'h240, 32'h0,         32'h0,         4'd6}, // R6
      '{2'd1, 10'h200, 32'h0,         32'h0000_0004, 4'd6}, // R6 state unchanged
      '{2'd1, 10'h170, 32'h0,         32'h0,         4'd7}  // R7 past data end
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0;
   logic        host_we = 1'b0;
   logic [9:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        host_irq;
   logic [6:0]  rmt_addr = '0;
   logic        rmt_we = 1'b0;
   logic [31:0] rmt_wdata = '0;
   logic [31:0] rmt_rdata;
   logic [11:0] rmt_ack = '0;
   logic [11:0] rmt_post = '0;
   logic [11:0] rmt_doorbell;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk; // 50 MHz

   mbx_doorbell_top i_mbx_doorbell_top (
      .clk(clk), .rst_n(rst_n),
      .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .host_irq(host_irq),
      .rmt_addr(rmt_addr), .rmt_we(rmt_we), .rmt_wdata(rmt_wdata),
      .rmt_rdata(rmt_rdata), .rmt_ack(rmt_ack), .rmt_post(rmt_post),
      .rmt_doorbell(rmt_doorbell)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic host_wr(input logic [9:0] a, input logic [31:0] d);
      @(negedge clk);
      host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_req = 1'b0; host_we = 1'b0;
   endtask

   task automatic host_rd(input logic [9:0] a, output logic [31:0] d);
      @(negedge clk);
      host_req = 1'b1; host_we = 1'b0; host_addr = a;
      @(negedge clk);
      host_req = 1'b0;
      d = host_rdata;
   endtask

   task automatic pulse_post(input logic [11:0] v);
      @(negedge clk); rmt_post = v;
      @(negedge clk); rmt_post = '0;
   endtask

   task automatic pulse_ack(input logic [11:0] v);
      @(negedge clk); rmt_ack = v;
      @(negedge clk); rmt_ack = '0;
   endtask

   task automatic rmt_rd(input logic [6:0] a, output logic [31:0] d);
      @(negedge clk); rmt_addr = a;
      @(negedge clk); d = rmt_rdata;
   endtask

   task automatic rmt_wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk); rmt_we = 1'b1; rmt_addr = a; rmt_wdata = d;
      @(negedge clk); rmt_we = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      chk("R1 irq", 32'(host_irq), 32'h0);
      chk("R1 doorbell", 32'(rmt_doorbell), 32'h0);
      host_rd(10'h200, rd); chk("R1 tx status", rd, 32'h0);
      host_rd(10'h278, rd); chk("R1 rx status", rd, 32'h0);
      host_rd(10'h0F0, rd); chk("R1 data word", rd, 32'h0);

      // table walk
      for (int i = 0; i < N_VEC; i++) begin
         case (int'(VEC[i].op))
            OP_HW: host_wr(VEC[i].addr, VEC[i].val);
            OP_HR: begin
               host_rd(VEC[i].addr, rd);
               chk($sformatf("R%0d vec %0d", VEC[i].req, i), rd, VEC[i].exp);
            end
            OP_PO: pulse_post(VEC[i].val[11:0]);
            default: pulse_ack(VEC[i].val[11:0]);
         endcase
      end

      // R2 doorbell vector toward remote side
      chk("R2 doorbell out", 32'(rmt_doorbell), 32'h0000_0004);

      // R5 interrupt follows receive bits
      pulse_post(12'h020);
      chk("R5 irq set", 32'(host_irq), 32'h1);
      host_wr(10'h274, 32'h0000_0020);
      chk("R5 irq clear", 32'(host_irq), 32'h0);

      // R4 collision: post and clear on ch3 in one cycle
      @(negedge clk);
      rmt_post = 12'h008;
      host_req = 1'b1; host_we = 1'b1; host_addr = 10'h274; host_wdata = 32'h8;
      @(negedge clk);
      rmt_post = '0; host_req = 1'b0; host_we = 1'b0;
      host_rd(10'h278, rd); chk("R4 post beats clear", rd, 32'h0000_0008);
      chk("R5 irq after collision", 32'(host_irq), 32'h1);
      host_wr(10'h274, 32'h8);
      host_rd(10'h278, rd); chk("R4 clear after collision", rd, 32'h0);

      // R3 collision: doorbell set and ack on ch7 in one cycle
      @(negedge clk);
      rmt_ack = 12'h080;
      host_req = 1'b1; host_we = 1'b1; host_addr = 10'h204; host_wdata = 32'h80;
      @(negedge clk);
      rmt_ack = '0; host_req = 1'b0; host_we = 1'b0;
      host_rd(10'h200, rd); chk("R3 set beats ack", rd, 32'h0000_0084);
      chk("R2 doorbell out after collision", 32'(rmt_doorbell), 32'h0000_0084);

      // R7 remote reads of outgoing windows
      rmt_rd(7'd0, rd);  chk("R7 remote read word 0", rd, 32'hA5A5_0001);
      rmt_rd(7'd55, rd); chk("R7 remote read word 55", rd, 32'h1234_5678);
      rmt_rd(7'd100, rd); chk("R7 remote read out of range", rd, 32'h0);

      // R8 remote writes to incoming windows only
      rmt_wr(7'd56, 32'hCAFE_F00D);
      host_rd(10'h0E0, rd); chk("R8 remote write lowest RX", rd, 32'hCAFE_F00D);
      rmt_wr(7'd91, 32'h0BAD_F00D);
      host_rd(10'h16C, rd); chk("R8 remote write highest RX", rd, 32'h0BAD_F00D);
      rmt_wr(7'd10, 32'h5555_AAAA);
      host_rd(10'h028, rd); chk("R8 remote write into TX ignored", rd, 32'h0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule